// File: doc/BRIEF.md
# Indexed Chipset Shadow-RAM Controller

This block is the configuration unit of a bus-era chipset. It sits on an 8-bit I/O bus that carries a 16-bit port address and separate read and write strobes. Software reaches a bank of 256 configuration bytes through two ports. One port selects a register. The other port reads or writes the selected register. Two more ports give direct access to two spare scratch bytes.

A few of those configuration bits drive a purely combinational memory-attribute decoder. For any 20-bit memory address, the decoder reports three things: whether reads go to internal RAM, whether writes go to internal RAM, and whether writes are blocked. The window from D0000h to EFFFFh is split into eight 16 KB segments. Each segment has its own shadow enable, and write protection is set separately for the D half and the E half. The top 64 KB holds the BIOS. Its handling depends on one mode bit, which lets the ROM be copied into RAM and then run from RAM. A further bit turns on an external-cache-enable output.

The I/O bus is a plain strobe interface with no back-pressure. A write takes effect on the clock edge where `io_wr` is high. Read data is combinational while `io_rd` is high.

Top module: `shadow_ctl`

## Requirements
- R1: A write to port 0022h loads the 8-bit index. A write to port 0024h stores the data byte into the configuration register the index selects. A read of port 0024h returns that register.
- R2: A read of port 0022h, or of any port other than 0024h, 00E1h and 00E2h, returns FFh. A write to an undecoded port changes no register. While `io_rd` is low, `io_rdata` is FFh.
- R3: Ports 00E1h and 00E2h are two independent read/write scratch bytes, and both come out of reset as FFh.
- R4: Reset clears the index and all 256 configuration registers to 00h. The external-cache-enable output is therefore low after reset.
- R5: Bit n of register 23h shadows the segment from D0000h + n·4000h through D0000h + n·4000h + 3FFFh, for n = 0 to 7. In an unprotected shadowed segment, the outputs are read-internal = 1, write-internal = 1 and write-disabled = 0.
- R6: Bit 4 of register 22h protects the shadowed segments below E0000h. In such a segment the outputs are read-internal = 1, write-internal = 0 and write-disabled = 1. This bit has no effect at E0000h or above.
- R7: Bit 3 of register 22h protects the shadowed segments from E0000h through EFFFFh, with the same output pattern as R6. This bit has no effect below E0000h.
- R8: A segment in D0000h–EFFFFh whose enable bit is clear drives all three attribute outputs low, so both reads and writes go to the external bus.
- R9: For F0000h–FFFFFh, when bit 7 of register 22h is set the outputs are read-internal = 0 and write-internal = 1. When the bit is clear both are 1. Write-disabled is always 0 in this range.
- R10: Addresses below D0000h drive all three attribute outputs low, whatever the register contents.
- R11: The external-cache-enable output follows bit 4 of register 21h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 16 | I/O port address |
| io_wr | input | 1 | I/O write strobe, sampled on the rising clock edge |
| io_rd | input | 1 | I/O read strobe |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data (combinational) |
| mem_addr | input | 20 | Memory address to classify |
| rd_internal | output | 1 | Reads at mem_addr go to internal RAM |
| wr_internal | output | 1 | Writes at mem_addr go to internal RAM |
| wr_disabled | output | 1 | Writes at mem_addr are blocked |
| ext_cache_en | output | 1 | External cache enable |

## Verification
The hardest case to reach from the ports is the one where both protect bits and several segment enables are set together. Only then does a fault that applies the wrong region's protect bit, or that checks the segment just past the boundary, change an output. Each vector in the bench therefore reprograms registers 22h and 23h through the index/data pair before it probes an address. The vectors pair opposite protect bits with segments on both sides of E0000h, and they include the last byte of the E region and the last byte below D0000h.

// File: rtl/shadow_pkg.sv
package shadow_pkg;
  typedef struct packed {
    logic rd_int;
    logic wr_int;
    logic wr_dis;
  } mem_attr_t;

  localparam mem_attr_t ATTR_EXT  = '{rd_int: 1'b0, wr_int: 1'b0, wr_dis: 1'b0};
  localparam mem_attr_t ATTR_RW   = '{rd_int: 1'b1, wr_int: 1'b1, wr_dis: 1'b0};
  localparam mem_attr_t ATTR_RO   = '{rd_int: 1'b1, wr_int: 1'b0, wr_dis: 1'b1};
  localparam mem_attr_t ATTR_COPY = '{rd_int: 1'b0, wr_int: 1'b1, wr_dis: 1'b0};
endpackage

// File: rtl/cfg_regfile.sv
module cfg_regfile #(
  parameter int AW        = 16,
  parameter int DW        = 8,
  parameter int NREG      = 256,
  parameter int NSEG      = 8,
  parameter logic [AW-1:0] IDX_PORT  = 16'h0022,
  parameter logic [AW-1:0] DATA_PORT = 16'h0024,
  parameter logic [AW-1:0] SCR0_PORT = 16'h00E1,
  parameter logic [AW-1:0] SCR1_PORT = 16'h00E2,
  parameter int CACHE_REG = 'h21,
  parameter int MODE_REG  = 'h22,
  parameter int SEG_REG   = 'h23,
  parameter int CACHE_BIT = 4,
  parameter int WPLO_BIT  = 4,
  parameter int WPHI_BIT  = 3,
  parameter int BIOS_BIT  = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   io_addr,
  input  logic            io_wr,
  input  logic            io_rd,
  input  logic [DW-1:0]   io_wdata,
  output logic [DW-1:0]   io_rdata,
  output logic            cache_en,
  output logic            wp_lo,
  output logic            wp_hi,
  output logic            bios_sh,
  output logic [NSEG-1:0] seg_en
);
  localparam int IW = $clog2(NREG);

  logic [IW-1:0] idx;
  logic [DW-1:0] regs [NREG];
  logic [DW-1:0] scr0, scr1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx  <= '0;
      scr0 <= '1;
      scr1 <= '1;
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (io_wr) begin
      if (io_addr == IDX_PORT)       idx       <= io_wdata[IW-1:0];
      else if (io_addr == DATA_PORT) regs[idx] <= io_wdata;
      else if (io_addr == SCR0_PORT) scr0      <= io_wdata;
      else if (io_addr == SCR1_PORT) scr1      <= io_wdata;
    end
  end

  always_comb begin
    io_rdata = '1;
    if (io_rd) begin
      if (io_addr == DATA_PORT)      io_rdata = regs[idx];
      else if (io_addr == SCR0_PORT) io_rdata = scr0;
      else if (io_addr == SCR1_PORT) io_rdata = scr1;
    end
  end

  assign cache_en = regs[CACHE_REG][CACHE_BIT];
  assign wp_lo    = regs[MODE_REG][WPLO_BIT];
  assign wp_hi    = regs[MODE_REG][WPHI_BIT];
  assign bios_sh  = regs[MODE_REG][BIOS_BIT];
  assign seg_en   = regs[SEG_REG][NSEG-1:0];

  // R1: an index write is visible on the next cycle
  assert_idx_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == IDX_PORT) |=> (idx == $past(io_wdata[IW-1:0])));

  // R2: the index port cannot be read back
  assert_idx_unreadable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && io_addr == IDX_PORT) |-> (io_rdata == '1));

  // R3: a scratch write that is not to the other port leaves the other byte stable
  assert_scratch_indep_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == SCR0_PORT) |=> $stable(scr1));
endmodule

// File: rtl/seg_decode.sv
module seg_decode
  import shadow_pkg::*;
#(
  parameter int MAW       = 20,
  parameter int SEG_BITS  = 14,
  parameter int NSEG      = 8,
  parameter int BASE_ADDR = 'hD0000,
  parameter int WP_SPLIT  = 'hE0000,
  parameter int BIOS_BASE = 'hF0000
) (
  input  logic [MAW-1:0]  addr,
  input  logic [NSEG-1:0] seg_en,
  input  logic            wp_lo,
  input  logic            wp_hi,
  input  logic            bios_sh,
  output mem_attr_t       attr
);
  localparam int SEG_SIZE = 1 << SEG_BITS;

  logic [MAW:0]    a;
  logic [NSEG-1:0] hit, lo_mask;
  logic            in_bios, shadow_hit, prot;

  assign a = {1'b0, addr};

  for (genvar g = 0; g < NSEG; g++) begin : g_seg
    localparam int LO = BASE_ADDR + g * SEG_SIZE;
    assign hit[g]     = (a >= (MAW+1)'(LO)) && (a < (MAW+1)'(LO + SEG_SIZE));
    assign lo_mask[g] = (LO < WP_SPLIT);
  end

  assign in_bios    = (a >= (MAW+1)'(BIOS_BASE));
  assign shadow_hit = |(hit & seg_en);
  assign prot       = (wp_lo && |(hit & seg_en & lo_mask)) ||
                      (wp_hi && |(hit & seg_en & ~lo_mask));

  always_comb begin
    attr = ATTR_EXT;
    if (in_bios)         attr = bios_sh ? ATTR_COPY : ATTR_RW;
    else if (shadow_hit) attr = prot ? ATTR_RO : ATTR_RW;
  end
endmodule

// File: rtl/shadow_ctl.sv
module shadow_ctl
  import shadow_pkg::*;
#(
  parameter int AW   = 16,
  parameter int DW   = 8,
  parameter int MAW  = 20,
  parameter int NSEG = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [AW-1:0]  io_addr,
  input  logic           io_wr,
  input  logic           io_rd,
  input  logic [DW-1:0]  io_wdata,
  output logic [DW-1:0]  io_rdata,
  input  logic [MAW-1:0] mem_addr,
  output logic           rd_internal,
  output logic           wr_internal,
  output logic           wr_disabled,
  output logic           ext_cache_en
);
  logic [NSEG-1:0] seg_en;
  logic            wp_lo, wp_hi, bios_sh;
  mem_attr_t       attr;

  cfg_regfile #(.AW(AW), .DW(DW), .NSEG(NSEG)) u_regs (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .cache_en(ext_cache_en),
    .wp_lo(wp_lo), .wp_hi(wp_hi), .bios_sh(bios_sh), .seg_en(seg_en)
  );

  seg_decode #(.MAW(MAW), .NSEG(NSEG)) u_dec (
    .addr(mem_addr), .seg_en(seg_en), .wp_lo(wp_lo), .wp_hi(wp_hi),
    .bios_sh(bios_sh), .attr(attr)
  );

  assign rd_internal = attr.rd_int;
  assign wr_internal = attr.wr_int;
  assign wr_disabled = attr.wr_dis;

  // R6/R7: a blocked write only occurs in a shadowed, read-internal segment
  assert_wp_shape_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_disabled |-> (rd_internal && !wr_internal));

  // R10: nothing below the shadow window gets attributes
  assert_low_region_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_addr < MAW'('hD0000)) |-> !(rd_internal || wr_internal || wr_disabled));

  // R9: the BIOS range is always internally writable
  assert_bios_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_addr >= MAW'('hF0000)) |-> (wr_internal && !wr_disabled));
endmodule

// File: tb/shadow_ctl_bench.sv
module shadow_ctl_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] io_addr = '0;
  logic        io_wr = 1'b0, io_rd = 1'b0;
  logic [7:0]  io_wdata = '0;
  logic [7:0]  io_rdata;
  logic [19:0] mem_addr = '0;
  logic        rd_internal, wr_internal, wr_disabled, ext_cache_en;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  shadow_ctl u_shadow_ctl (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .mem_addr(mem_addr),
    .rd_internal(rd_internal), .wr_internal(wr_internal),
    .wr_disabled(wr_disabled), .ext_cache_en(ext_cache_en)
  );

  // {reg22, reg23, mem_addr, {rd_int, wr_int, wr_dis}}
  localparam int NV = 12;
  localparam logic [38:0] VEC [NV] = '{
    {8'h00, 8'h01, 20'hD0000, 3'b110},  // R5 segment 0 shadowed
    {8'h00, 8'h01, 20'hD4000, 3'b000},  // R8 segment 1 off
    {8'h10, 8'h01, 20'hD3FFF, 3'b101},  // R6 D protect
    {8'h10, 8'h10, 20'hE0000, 3'b110},  // R6 no effect in E
    {8'h08, 8'h10, 20'hE0000, 3'b101},  // R7 E protect
    {8'h08, 8'h08, 20'hDC000, 3'b110},  // R7 no effect in D
    {8'h18, 8'h80, 20'hEFFFF, 3'b101},  // R7 last segment
    {8'h00, 8'hFF, 20'hCFFFF, 3'b000},  // R10 below window
    {8'h00, 8'h00, 20'hF0000, 3'b110},  // R9 bios bit clear
    {8'h80, 8'h00, 20'hFFFFF, 3'b010},  // R9 bios bit set
    {8'h80, 8'hFF, 20'h00000, 3'b000},  // R10 bottom
    {8'h18, 8'hFE, 20'hD0000, 3'b000}   // R8 others on, this off
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic io_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic io_read(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    #1 d = io_rdata;
    io_rd = 1'b0;
  endtask

  task automatic set_reg(input logic [7:0] r, input logic [7:0] d);
    io_write(16'h0022, r);
    io_write(16'h0024, d);
  endtask

  task automatic probe(input string req, input logic [19:0] a, input logic [2:0] exp);
    @(negedge clk);
    mem_addr = a;
    #1 check(req, {29'd0, rd_internal, wr_internal, wr_disabled}, {29'd0, exp});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state R4, R3
    io_read(16'h0024, d);  check("R4 reg0", d, 8'h00);
    io_read(16'h00E1, d);  check("R3 scr0 reset", d, 8'hFF);
    io_read(16'h00E2, d);  check("R3 scr1 reset", d, 8'hFF);
    check("R4 cache", ext_cache_en, 1'b0);
    probe("R4 decode F0000", 20'hF0000, 3'b110);
    probe("R4 decode D0000", 20'hD0000, 3'b000);

    for (int i = 0; i < NV; i++) begin
      set_reg(8'h22, VEC[i][38:31]);
      set_reg(8'h23, VEC[i][30:23]);
      probe($sformatf("vec%0d R5-R10", i), VEC[i][22:3], VEC[i][2:0]);
    end

    // R1 index/data
    set_reg(8'h5A, 8'hA5);
    io_read(16'h0024, d);  check("R1 readback", d, 8'hA5);
    io_write(16'h0022, 8'h5B);
    io_read(16'h0024, d);  check("R1 other reg", d, 8'h00);
    io_write(16'h0022, 8'h5A);
    io_read(16'h0024, d);  check("R1 reselect", d, 8'hA5);

    // R2 unreadable index and undecoded ports
    io_read(16'h0022, d);  check("R2 index port", d, 8'hFF);
    io_read(16'h0030, d);  check("R2 undecoded", d, 8'hFF);
    io_write(16'h0030, 8'h11);
    io_write(16'h0025, 8'h22);
    io_read(16'h0024, d);  check("R2 write ignored", d, 8'hA5);
    io_read(16'h00E1, d);  check("R2 scratch kept", d, 8'hFF);
    @(negedge clk); io_addr = 16'h0024; #1 check("R2 no strobe", io_rdata, 8'hFF);

    // R3 scratch
    io_write(16'h00E1, 8'h12);
    io_write(16'h00E2, 8'h34);
    io_read(16'h00E1, d);  check("R3 scr0", d, 8'h12);
    io_read(16'h00E2, d);  check("R3 scr1", d, 8'h34);

    // R11 cache enable
    set_reg(8'h21, 8'h10);
    @(negedge clk); check("R11 on", ext_cache_en, 1'b1);
    set_reg(8'h21, 8'hEF);
    @(negedge clk); check("R11 off", ext_cache_en, 1'b0);

    // R6/R7 both protects, boundary segments
    set_reg(8'h22, 8'h18);
    set_reg(8'h23, 8'h18);
    probe("R6 seg3 end", 20'hDFFFF, 3'b101);
    probe("R7 seg4 start", 20'hE0000, 3'b101);
    probe("R8 seg5", 20'hE4000, 3'b000);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule